// File: doc/BRIEF.md
# Fractional-Increment Real-Time Counter

This block keeps a free-running 64-bit tick count that advances at a fixed nominal rate of 6.144 MHz, whatever reference clock happens to drive it. It does not add one on every reference edge. It adds a programmable numerator to a fractional accumulator on each edge. When the accumulator reaches the programmed denominator, the denominator is taken back out and the tick count steps by one. Software picks a numerator/denominator pair that matches the reference frequency, so the count rate is the reference frequency times num/den.

The ratio is programmed through two 32-bit registers on a simple write port, and both can be read back. The first register holds a staged numerator. Writing the second register supplies the denominator and, in the same edge, moves the staged numerator and the new denominator into the active ratio and clears the accumulator. Because of this, a ratio that is only half written never reaches the counting logic. Only the low 12 bits of each register are storage. The bits above them are reserved and are never changed by a write.

Top module: `frac_rt_counter`

## Requirements
- R1: After synchronous reset the tick count and accumulator are zero, the active ratio is 4/25, and the two registers read back 0x00000004 (numerator) and 0x00000019 (denominator).
- R2: On each clock the active numerator is added to the accumulator; when the sum is at least the active denominator, the denominator is subtracted and the count goes up by one, so k clocks after a reload the count has risen by floor(k*num/den).
- R3: The count rises by at most one per clock.
- R4: The numerator register is at byte address 0x10 and the denominator/reload register at 0x14; the value sits in bits 11:0, and bits 31:12 read as zero and keep that value whatever a write carries.
- R5: A write to the numerator register alone does not change the rate in use.
- R6: A write to the denominator register applies the staged numerator and the new denominator together and clears the accumulator; that edge adds no tick.
- R7: A denominator of zero is used as one, so the counter cannot stall on a nonzero numerator.
- R8: A numerator above the denominator is clamped to the denominator, which gives exactly one tick per clock.
- R9: Writes to any other address change nothing, and reads of any other address return zero.
- R10: The ratios 4/25, 8/25, 384/1625, 256/1125, 768/1625 and 64/125 each give their exact long-run tick count over a whole number of ratio periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the combinational read |
| rd_data | output | 32 | Read data |
| tick_count | output | CNT_W | Free-running tick count |

## Verification
The bench checks whether a reload really discards the remainder left in the accumulator. It reloads partway through a ratio period. A design that kept the old remainder would then produce one tick too early. The bench also writes only the numerator to show that a staged value stays inert: a design that applied it at once would change the rate before the denominator write. Zero and oversized denominators are run to catch two faults, a counter that stalls and a counter that adds two ticks in one clock. The standard ratios, plus one ratio that does not divide evenly, are run over many cycles so that an off-by-one in the compare against the denominator builds up into a visible tick error.

// File: rtl/frac_rt_pkg.sv
package frac_rt_pkg;

    localparam int FRAC_W = 12;
    localparam int REG_W  = 32;

    localparam logic [7:0] NUM_OFS = 8'h10;
    localparam logic [7:0] DEN_OFS = 8'h14;

    localparam logic [FRAC_W-1:0] NUM_RST = 12'd4;
    localparam logic [FRAC_W-1:0] DEN_RST = 12'd25;

    typedef struct packed {
        logic [FRAC_W-1:0] num;
        logic [FRAC_W-1:0] den;
    } ratio_t;

    // Make a written pair safe to count with: zero denominator -> 1,
    // numerator above denominator -> denominator.
    function automatic ratio_t sanitize(input logic [FRAC_W-1:0] n,
                                        input logic [FRAC_W-1:0] d);
        ratio_t r;
        r.den = (d == '0) ? FRAC_W'(1) : d;
        r.num = (n > r.den) ? r.den : n;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pad_field(input logic [FRAC_W-1:0] v);
        return {{(REG_W-FRAC_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/frac_rt_regs.sv
module frac_rt_regs
    import frac_rt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output ratio_t            active,
    output logic              reload
);
    localparam logic [ADDR_W-1:0] A_NUM = ADDR_W'(NUM_OFS);
    localparam logic [ADDR_W-1:0] A_DEN = ADDR_W'(DEN_OFS);

    logic [FRAC_W-1:0] num_q;
    logic [FRAC_W-1:0] den_q;
    logic              hit_num;

    assign hit_num = wr_en && (wr_addr == A_NUM);
    assign reload  = wr_en && (wr_addr == A_DEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q  <= NUM_RST;
            den_q  <= DEN_RST;
            active <= sanitize(NUM_RST, DEN_RST);
        end else begin
            if (hit_num) num_q <= wr_data[FRAC_W-1:0];
            if (reload) begin
                den_q  <= wr_data[FRAC_W-1:0];
                active <= sanitize(num_q, wr_data[FRAC_W-1:0]);
            end
        end
    end

    always_comb begin
        if (rd_addr == A_NUM)      rd_data = pad_field(num_q);
        else if (rd_addr == A_DEN) rd_data = pad_field(den_q);
        else                       rd_data = '0;
    end

    // R5: a numerator-only write must not disturb the ratio in use
    assert_num_staged_R5: assert property (@(posedge clk) disable iff (rst)
        (hit_num && !reload) |=> $stable(active));

    // R7, R8: the active ratio is always usable
    assert_ratio_sane_R7: assert property (@(posedge clk) disable iff (rst)
        (active.den != '0) && (active.num <= active.den));

endmodule

// File: rtl/frac_rt_accum.sv
module frac_rt_accum
    import frac_rt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ratio_t active,
    input  logic   reload,
    output logic   tick
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;
    logic              reached;

    assign sum     = {1'b0, acc_q} + {1'b0, active.num};
    assign reached = (sum >= {1'b0, active.den});
    assign tick    = reached && !reload;

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            acc_q <= '0;
        end else if (reached) begin
            acc_q <= FRAC_W'(sum - {1'b0, active.den});
        end else begin
            acc_q <= sum[FRAC_W-1:0];
        end
    end

    // R2: remainder stays below the denominator
    assert_acc_below_den_R2: assert property (@(posedge clk) disable iff (rst)
        acc_q < active.den);

    // R6: reload leaves a clean accumulator
    assert_reload_clears_R6: assert property (@(posedge clk) disable iff (rst)
        reload |=> (acc_q == '0));

endmodule

// File: rtl/frac_rt_tick.sv
module frac_rt_tick #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else if (tick) count <= count + CNT_W'(1);
    end

    // R3: never more than one step per clock
    assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
        (count == $past(count)) || (count == $past(count) + CNT_W'(1)));

    // R1: reset clears the count
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (count == '0));

endmodule

// File: rtl/frac_rt_counter.sv
module frac_rt_counter
    import frac_rt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic [CNT_W-1:0]  tick_count
);
    ratio_t active;
    logic   reload;
    logic   tick;

    frac_rt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .active  (active),
        .reload  (reload)
    );

    frac_rt_accum u_accum (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .reload (reload),
        .tick   (tick)
    );

    frac_rt_tick #(.CNT_W(CNT_W)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .count (tick_count)
    );

endmodule

// File: tb/frac_rt_counter_bench.sv
`timescale 1ns/1ps
module frac_rt_counter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] tick_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    frac_rt_counter u_frac_rt_counter (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .tick_count (tick_count)
    );

    // {num[11:0], den[11:0], cycles[19:0], expected ticks[19:0]}
    localparam int NV = 11;
    localparam logic [63:0] VEC [NV] = '{
        {12'd4,   12'd25,   20'd1000, 20'd160},
        {12'd8,   12'd25,   20'd1000, 20'd320},
        {12'd384, 12'd1625, 20'd3250, 20'd768},
        {12'd256, 12'd1125, 20'd2250, 20'd512},
        {12'd768, 12'd1625, 20'd3250, 20'd1536},
        {12'd64,  12'd125,  20'd1000, 20'd512},
        {12'd4,   12'd25,   20'd37,   20'd5},
        {12'd7,   12'd13,   20'd100,  20'd53},
        {12'd5,   12'd0,    20'd50,   20'd50},
        {12'd0,   12'd0,    20'd50,   20'd0},
        {12'd30,  12'd20,   20'd40,   20'd40}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_addr = a;
        #0.5;
        check(req, {32'd0, rd_data}, {32'd0, exp});
    endtask

    // advance n edges, return count delta seen at the following negedge
    task automatic run(input int n, output logic [63:0] delta);
        logic [63:0] c0;
        c0 = tick_count;
        repeat (n) @(posedge clk);
        @(negedge clk);
        delta = tick_count - c0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state (edge to negedge already sampled after release)
        check("R1 count", tick_count, 64'd0);
        rd_check("R1 num reg", 8'h10, 32'h4);
        rd_check("R1 den reg", 8'h14, 32'h19);
        // R1: default 4/25 from reset; count started at zero
        repeat (23) @(posedge clk);
        @(negedge clk);
        check("R1 default rate", tick_count, 64'd4);

        // R2, R10, R7, R8: table of ratios
        for (int i = 0; i < NV; i++) begin
            wr(8'h10, {20'd0, VEC[i][63:52]});
            wr(8'h14, {20'd0, VEC[i][51:40]});
            run(int'(VEC[i][39:20]), d);
            check($sformatf("R2/R10 vec %0d", i), d, {44'd0, VEC[i][19:0]});
        end

        // R4: upper bits are reserved and read zero
        wr(8'h10, 32'hFFFF_F0AB);
        rd_check("R4 num upper", 8'h10, 32'h0000_00AB);
        wr(8'h14, 32'hABCD_E0C8);
        rd_check("R4 den upper", 8'h14, 32'h0000_00C8);

        // R6: reload mid-period discards remainder (4/25, 20 clocks -> rem 5)
        wr(8'h10, 32'd4);
        wr(8'h14, 32'd25);
        run(20, d);
        check("R6 pre", d, 64'd3);
        wr(8'h14, 32'd25);
        run(6, d);
        check("R6 cleared acc", d, 64'd0);

        // R5: staged numerator inert until reload
        wr(8'h14, 32'd25);
        wr(8'h10, 32'd8);
        run(100, d);
        check("R5 staged inert", d, 64'd16);
        wr(8'h14, 32'd25);
        run(100, d);
        check("R5 applied", d, 64'd32);

        // R9: other addresses ignored, read zero
        wr(8'h18, 32'd7);
        wr(8'h00, 32'd1);
        rd_check("R9 num kept", 8'h10, 32'd8);
        rd_check("R9 den kept", 8'h14, 32'd25);
        rd_check("R9 other reads zero", 8'h18, 32'd0);
        run(25, d);
        check("R9 rate kept", d, 64'd8);

        // R3: ratio 1 gives one tick per clock, not more
        wr(8'h10, 32'd50);
        wr(8'h14, 32'd50);
        run(10, d);
        check("R3 one per clock", d, 64'd10);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule